// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the SCL waveform for an I2C master. It works from an 8-bit control byte and a 4 MHz tick enable, so every timing step is 250 ns. A 4-bit rate code selects one of sixteen bit periods. A push-pull enable shortens those periods to roughly double the rate. A fast-mode enable limits how fast the bus may run. A 2-bit selector chooses which of two physical bus pairs receives the clock.

The byte sequencer above the block asks for one bit at a time by holding a request line. It sees a strobe when each bit starts and another when each bit ends. If the request is still high at the end of a bit, the next bit follows with no gap. During acknowledge or slave-data bits the sequencer raises a receive flag. The generator then drops to open-drain driving with active pull-up off, at half the push-pull rate. Control-byte changes are taken only at bit boundaries, so a bit that is already running keeps its shape.

Top module: `i2c_scl_rategen`

## Requirements
- R1: After reset the control byte is treated as 0x00. Bus 0 is claimed (`scl_oe_o`=01), its SCL is high, `pp_drv_o`=00, and neither strobe is active.
- R2: With push-pull off, rate codes 0 to 15 give periods of round(4000/f) ticks. The values of f in kHz are 20.10, 30.53, 40.40, 50.63, 63.49, 72.73, 85.11, 102.56, 129.03, 173.91, 210.53, 266.67, 400.00, 444.44, 444.44 and 666.67. For example, code 0 gives 199 ticks and code 12 gives 10 ticks.
- R3: With push-pull on (control bit 4 = 1) and receive low, codes 0 to 13 give round(4000/f) ticks. The values of f in kHz are 40.40, 61.54, 81.63, 102.56, 129.03, 148.15, 173.91, 210.53, 266.67, 363.64, 444.44, 444.44, 571.43 and 666.67. `pp_drv_o` is high on the selected bus while such a bit runs.
- R4: For effective codes 14 and 15, push-pull is forced off. These codes use the R2 periods of 9 and 6 ticks, and `pp_drv_o` stays low.
- R5: When fast mode is off (control bit 5 = 0), any rate code above 7 behaves as code 7.
- R6: When push-pull is in effect and `rx_phase_i` is high at bit start, the bit uses twice the R3 period and `pp_drv_o` is low. When push-pull is not in effect, `rx_phase_i` has no effect on the period.
- R7: Each bit is SCL low for ceil(P/2) ticks and then high for floor(P/2) ticks. SCL changes only on cycles where `tick_i` is high.
- R8: A change to the control byte or to `rx_phase_i` during a bit does not alter that bit. It applies from the next bit start.
- R9: Control bits 7:6 select the bus: 0 selects bus 0, 1 selects bus 1, and 2 or 3 selects neither. On any bus that is not selected, `scl_oe_o`, `scl_o` and `pp_drv_o` are low.
- R10: A bit starts on the first tick where `bit_req_i` is high while idle. `bit_start_o` pulses for one cycle as SCL falls, and `bit_end_o` pulses for one cycle at the end of the high phase. If the request is still high at that point, the next bit starts on the same tick. While the request is low and the block is idle, SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 250 ns timing enable, one cycle wide |
| cfg_i | input | 8 | Control byte: [7:6] bus select, [5] fast mode, [4] push-pull, [3:0] rate code |
| bit_req_i | input | 1 | Request to run a bit; hold high for back-to-back bits |
| rx_phase_i | input | 1 | Current bit is an acknowledge or slave-data bit |
| scl_o | output | 2 | SCL level per bus |
| scl_oe_o | output | 2 | Bus claimed by this interface, per bus |
| pp_drv_o | output | 2 | Drive type per bus: 1 push-pull, 0 open-drain |
| bit_start_o | output | 1 | One-cycle strobe at the start of a bit |
| bit_end_o | output | 1 | One-cycle strobe at the end of a bit |

## Verification
The assertions rely on `tick_i` being a single-cycle enable and on `bit_req_i` changing only between ticks. The bench meets both conditions: it generates the tick itself on every second clock and drives the request at falling edges. The bench also assumes the minimum period of six ticks, so the two strobes of one bit can never merge. Control bytes are kept within the defined layout, and bus codes 2 and 3 are driven on purpose so that the release path is exercised.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  localparam int PER_W    = 8;
  localparam int Q_W      = 4;
  localparam int SEL_W    = 2;
  localparam int CFG_W    = 8;
  localparam int FM_BIT   = 5;
  localparam int PP_BIT   = 4;
  localparam int Q_CAP    = 7;   // highest code allowed without fast mode
  localparam int PP_OFF_Q = 14;  // first code with push-pull forced off

  typedef struct packed {
    logic [SEL_W-1:0] bus;
    logic             pp;
    logic [Q_W-1:0]   q;
    logic [PER_W-1:0] per;
  } rate_cfg_t;

  localparam rate_cfg_t CFG_RST = '{bus: '0, pp: 1'b0, q: '0, per: PER_W'(199)};

  function automatic logic [PER_W-1:0] od_period(input logic [Q_W-1:0] q);
    case (q)
      4'd0:  return PER_W'(199);
      4'd1:  return PER_W'(131);
      4'd2:  return PER_W'(99);
      4'd3:  return PER_W'(79);
      4'd4:  return PER_W'(63);
      4'd5:  return PER_W'(55);
      4'd6:  return PER_W'(47);
      4'd7:  return PER_W'(39);
      4'd8:  return PER_W'(31);
      4'd9:  return PER_W'(23);
      4'd10: return PER_W'(19);
      4'd11: return PER_W'(15);
      4'd12: return PER_W'(10);
      4'd13: return PER_W'(9);
      4'd14: return PER_W'(9);
      default: return PER_W'(6);
    endcase
  endfunction

  function automatic logic [PER_W-1:0] pp_period(input logic [Q_W-1:0] q);
    case (q)
      4'd0:  return PER_W'(99);
      4'd1:  return PER_W'(65);
      4'd2:  return PER_W'(49);
      4'd3:  return PER_W'(39);
      4'd4:  return PER_W'(31);
      4'd5:  return PER_W'(27);
      4'd6:  return PER_W'(23);
      4'd7:  return PER_W'(19);
      4'd8:  return PER_W'(15);
      4'd9:  return PER_W'(11);
      4'd10: return PER_W'(9);
      4'd11: return PER_W'(9);
      4'd12: return PER_W'(7);
      default: return PER_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/i2c_rate_decode.sv
module i2c_rate_decode
  import i2c_rate_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             rx_i,
  output rate_cfg_t        cfg_o
);
  logic [Q_W-1:0]   q_raw, q_eff;
  logic             pp_eff;
  logic [PER_W-1:0] pp_per;

  always_comb begin
    q_raw  = cfg_i[Q_W-1:0];
    q_eff  = (!cfg_i[FM_BIT] && (q_raw > Q_W'(Q_CAP))) ? Q_W'(Q_CAP) : q_raw;
    pp_eff = cfg_i[PP_BIT] && (q_eff < Q_W'(PP_OFF_Q));
    pp_per = pp_period(q_eff);
    cfg_o.bus = cfg_i[CFG_W-1 -: SEL_W];
    cfg_o.q   = q_eff;
    cfg_o.pp  = pp_eff && !rx_i;
    if (!pp_eff)   cfg_o.per = od_period(q_eff);
    else if (rx_i) cfg_o.per = pp_per << 1;  // receive bits: open-drain, half rate
    else           cfg_o.per = pp_per;
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_rate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      req_i,
  input  rate_cfg_t cfg_d_i,
  output rate_cfg_t cfg_q_o,
  output logic      scl_o,
  output logic      run_o,
  output logic      start_o,
  output logic      end_o
);
  logic [PER_W-1:0] cnt_q, lo_len, hi_len;
  logic             hi_q;

  assign lo_len = (cfg_q_o.per >> 1) + PER_W'(cfg_q_o.per[0]);
  assign hi_len = cfg_q_o.per >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q_o <= CFG_RST;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      scl_o   <= 1'b1;
      run_o   <= 1'b0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      if (!run_o) begin
        cfg_q_o <= cfg_d_i;  // idle is a boundary: follow the register
        if (tick_i && req_i) begin
          run_o   <= 1'b1;
          hi_q    <= 1'b0;
          cnt_q   <= '0;
          scl_o   <= 1'b0;
          start_o <= 1'b1;
        end
      end else if (tick_i) begin
        if (!hi_q) begin
          if (cnt_q == lo_len - 1'b1) begin
            hi_q  <= 1'b1;
            cnt_q <= '0;
            scl_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == hi_len - 1'b1) begin
          end_o <= 1'b1;
          if (req_i) begin
            cfg_q_o <= cfg_d_i;
            hi_q    <= 1'b0;
            cnt_q   <= '0;
            scl_o   <= 1'b0;
            start_o <= 1'b1;
          end else begin
            run_o <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_bus_route.sv
module i2c_bus_route
  import i2c_rate_pkg::*;
#(
  parameter int NUM_BUS = 2
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               scl_i,
  input  logic               pp_i,
  output logic [NUM_BUS-1:0] scl_o,
  output logic [NUM_BUS-1:0] oe_o,
  output logic [NUM_BUS-1:0] pp_o
);
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic hit;
    assign hit      = (sel_i == SEL_W'(b));
    assign oe_o[b]  = hit;
    assign scl_o[b] = hit & scl_i;
    assign pp_o[b]  = hit & pp_i;
  end
endmodule

// File: rtl/i2c_scl_rategen.sv
module i2c_scl_rategen
  import i2c_rate_pkg::*;
#(
  parameter int NUM_BUS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic               bit_req_i,
  input  logic               rx_phase_i,
  output logic [NUM_BUS-1:0] scl_o,
  output logic [NUM_BUS-1:0] scl_oe_o,
  output logic [NUM_BUS-1:0] pp_drv_o,
  output logic               bit_start_o,
  output logic               bit_end_o
);
  rate_cfg_t        cfg_d, cfg_q;
  logic             scl_lvl, run_q;
  logic [PER_W-1:0] per_q;
  logic [Q_W-1:0]   q_q;

  assign per_q = cfg_q.per;
  assign q_q   = cfg_q.q;

  i2c_rate_decode u_dec (
    .cfg_i (cfg_i),
    .rx_i  (rx_phase_i),
    .cfg_o (cfg_d)
  );

  i2c_bit_timer u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .req_i   (bit_req_i),
    .cfg_d_i (cfg_d),
    .cfg_q_o (cfg_q),
    .scl_o   (scl_lvl),
    .run_o   (run_q),
    .start_o (bit_start_o),
    .end_o   (bit_end_o)
  );

  i2c_bus_route #(.NUM_BUS(NUM_BUS)) u_route (
    .sel_i (cfg_q.bus),
    .scl_i (scl_lvl),
    .pp_i  (cfg_q.pp),
    .scl_o (scl_o),
    .oe_o  (scl_oe_o),
    .pp_o  (pp_drv_o)
  );
endmodule

// File: rtl/i2c_scl_rategen_chk.sv
module i2c_scl_rategen_chk
  import i2c_rate_pkg::*;
#(
  parameter int NUM_BUS = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [NUM_BUS-1:0] scl_o,
  input logic [NUM_BUS-1:0] scl_oe_o,
  input logic [NUM_BUS-1:0] pp_drv_o,
  input logic               bit_start_o,
  input logic               bit_end_o,
  input logic               scl_lvl,
  input logic               run_q,
  input logic [PER_W-1:0]   per_q,
  input logic [Q_W-1:0]     q_q
);
  assert_start_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |=> !bit_start_o);
  assert_end_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> !bit_end_o);
  assert_start_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |-> !scl_lvl);
  assert_one_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(scl_oe_o));
  assert_unsel_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~scl_oe_o) & (scl_o | pp_drv_o)) == '0);
  assert_pp_off_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pp_drv_o) |-> (q_q < Q_W'(PP_OFF_Q)));
  assert_scl_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(scl_lvl));
  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(per_q) && $past(run_q)) |-> bit_start_o);
endmodule

bind i2c_scl_rategen i2c_scl_rategen_chk #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .scl_o       (scl_o),
  .scl_oe_o    (scl_oe_o),
  .pp_drv_o    (pp_drv_o),
  .bit_start_o (bit_start_o),
  .bit_end_o   (bit_end_o),
  .scl_lvl     (scl_lvl),
  .run_q       (run_q),
  .per_q       (per_q),
  .q_q         (q_q)
);

// File: tb/i2c_scl_rategen_bench.sv
module i2c_scl_rategen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       req = 1'b0;
  logic       rx = 1'b0;
  logic [1:0] scl, oe, ppd;
  logic       bst, bend;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  bit done = 0;

  real od_khz[16] = '{20.10, 30.53, 40.40, 50.63, 63.49, 72.73, 85.11, 102.56,
                      129.03, 173.91, 210.53, 266.67, 400.00, 444.44, 444.44, 666.67};
  real pp_khz[16] = '{40.40, 61.54, 81.63, 102.56, 129.03, 148.15, 173.91, 210.53,
                      266.67, 363.64, 444.44, 444.44, 571.43, 666.67, 666.67, 666.67};

  i2c_scl_rategen u_i2c_scl_rategen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .cfg_i       (cfg),
    .bit_req_i   (req),
    .rx_phase_i  (rx),
    .scl_o       (scl),
    .scl_oe_o    (oe),
    .pp_drv_o    (ppd),
    .bit_start_o (bst),
    .bit_end_o   (bend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  always @(posedge clk) if (tick) tcnt <= tcnt + 1;

  function automatic int ticks_of(input real khz);
    return $rtoi(4000.0 / khz + 0.5);
  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // one bit on bus 0; returns low/high lengths in ticks and drive type seen at start
  task automatic run_bit(input logic [7:0] c, input logic r,
                         output int lo, output int hi, output logic ppo);
    int t0, t1;
    @(negedge clk);
    cfg = c; rx = r; req = 1'b1;
    while (!bst) @(negedge clk);
    t0 = tcnt; ppo = ppd[0]; req = 1'b0;
    while (!scl[0]) @(negedge clk);
    t1 = tcnt;
    while (!bend) @(negedge clk);
    lo = t1 - t0; hi = tcnt - t1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lo, hi, per, qe, l2;
    logic ppo, ppe;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state, R10 idle with request low
    check(scl == 2'b01, "R1 scl", scl, 1);
    check(oe == 2'b01, "R1 oe", oe, 1);
    check(ppd == 2'b00, "R1 pp", ppd, 0);
    check(!bst && !bend, "R10 idle strobes", {bst, bend}, 0);

    for (int fm = 0; fm < 2; fm++)
      for (int pp = 0; pp < 2; pp++)
        for (int q = 0; q < 16; q++)
          for (int r = 0; r < 2; r++) begin
            qe  = (fm == 0 && q > 7) ? 7 : q;
            ppe = (pp == 1) && (qe < 14);
            if (!ppe)   per = ticks_of(od_khz[qe]);
            else if (r) per = 2 * ticks_of(pp_khz[qe]);
            else        per = ticks_of(pp_khz[qe]);
            if (fm == 0 && q > 7)            tag = "R5";
            else if (pp == 1 && qe >= 14)    tag = "R4";
            else if (ppe && r == 1)          tag = "R6";
            else if (ppe)                    tag = "R3";
            else                             tag = "R2";
            run_bit({2'b00, 1'(fm), 1'(pp), 4'(q)}, 1'(r), lo, hi, ppo);
            check(lo + hi == per, {tag, " period"}, lo + hi, per);
            check(lo == (per + 1) / 2 && hi == per / 2, "R7 split", lo, (per + 1) / 2);
            check(ppo == (ppe && r == 0), {tag, " drive"}, ppo, ppe && r == 0);
          end

    // R8: change register and receive flag mid-bit; R10 back-to-back bits
    @(negedge clk);
    cfg = 8'h3C; rx = 1'b0; req = 1'b1;  // pp, q=12: 7 ticks
    while (!bst) @(negedge clk);
    cfg = 8'h30; rx = 1'b1;              // would give 198 ticks
    lo = tcnt;
    while (!scl[0]) @(negedge clk);
    hi = tcnt;
    while (!bend) @(negedge clk);
    check(hi - lo == 4 && tcnt - hi == 3, "R8 old bit kept", tcnt - lo, 7);
    check(bst == 1'b1 && scl[0] == 1'b0, "R10 back-to-back start", bst, 1);
    req = 1'b0;
    lo = tcnt;
    while (!scl[0]) @(negedge clk);
    check(tcnt - lo == 99, "R8 new cfg applied", tcnt - lo, 99);
    check(ppd[0] == 1'b0, "R6 rx open-drain", ppd[0], 0);
    while (!bend) @(negedge clk);
    l2 = tcnt;
    repeat (20) @(negedge clk);
    check(scl[0] == 1'b1 && tcnt - l2 >= 8, "R10 idle high", scl[0], 1);

    // R9 bus routing
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      cfg = {2'(s), 6'b01_1100}; rx = 1'b0; req = 1'b1;
      while (!bst) @(negedge clk);
      check(oe == ((s < 2) ? 2'(1 << s) : 2'b00), "R9 oe", oe, (s < 2) ? (1 << s) : 0);
      check(scl == 2'b00, "R9 scl low", scl, 0);
      check(ppd == oe, "R9 pp", ppd, oe);
      req = 1'b0;
      while (bst || scl != oe) @(negedge clk);
      check(scl == oe, "R9 scl high", scl, oe);
      while (!bend) @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule